// File: doc/BRIEF.md
# Rate-Trimmed Nanosecond Time Counter

This block keeps the local time for a network timestamping engine. Each pulse on the base tick input marks one 8 ns period of the timing clock. On each pulse the nanosecond count moves forward by a fixed 8 ns. A signed sub-nanosecond correction, held in a software-programmed increment register, is summed into a 32-bit fractional accumulator. When that accumulator carries out, the tick adds one extra nanosecond. When it borrows, the tick gives up one nanosecond. A rate offset of p parts per billion corresponds to an increment magnitude of p·2^35/10^9, in units of 2^-32 ns per tick.

Software reaches the block through a simple word-wide register port. Reading the residue word returns the live fractional accumulator. The same read copies the 40-bit time into a snapshot, and the low and high time words are then read from that snapshot, so a multi-word read stays coherent. Writing time is a two-step sequence: the low word is held, and the counter loads the full value when the high word is written. The live 40-bit count is also driven out for the stamping logic, and it wraps about every 18.3 minutes.

Top module: `ptp_rate_clock`

## Requirements
- R1: After a synchronous active-high reset, the time and the fractional accumulator are zero and the increment register reads zero. The control word (address 0) reads 0x8000_0000, meaning the timer is stopped.
- R2: While bit 31 of the control word is 1, base ticks leave the time and the accumulator unchanged. Writing 0x0000_0000 to address 0 starts the timer, and writing 0x8000_0000 stops it again.
- R3: With the timer running and an increment of zero, each base tick adds exactly 8 to the time. Cycles without a tick leave the time unchanged.
- R4: With bit 31 of the increment register (address 1) at 0, bits 30:0 are added to the accumulator on each tick. A tick whose addition carries out of 32 bits adds 9 ns instead of 8.
- R5: With bit 31 of the increment register at 1, bits 30:0 are subtracted from the accumulator on each tick. A tick whose subtraction borrows adds 7 ns instead of 8.
- R6: A write to the low time word (address 3) leaves the running time unchanged. A following write to the high time word (address 4) loads {high[7:0], low} into the time in one step and clears the accumulator.
- R7: The time is 40 bits wide. Bits 31:8 of the high time word always read zero, and on reaching 2^40 the count wraps to zero.
- R8: A read of the residue word (address 2) returns the live accumulator and copies the time into a snapshot. Later reads of addresses 3 and 4 return that snapshot even after the time has moved on.
- R9: The increment register reads back exactly the 32-bit value written, sign bit included.
- R10: A high-word write that arrives in the same cycle as a base tick takes priority: the time equals the loaded value, and no 8 ns step is added on top of it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timing clock |
| rst | input | 1 | Synchronous active-high reset |
| baseTick | input | 1 | One-cycle pulse marking an 8 ns period |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe; a read of address 2 captures the snapshot |
| regAddr | input | 3 | Register word select (0 control, 1 increment, 2 residue, 3 time low, 4 time high) |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Read data for the selected word while regRdEn is high, zero otherwise |
| timeNs | output | 40 | Live nanosecond count |

## Verification
The bench drives the accumulator over its 32-bit boundary in both directions. A design that dropped the carry or the borrow would show 32 instead of 33 after four positive quarter-nanosecond ticks, or 32 instead of 31 after four negative ones. A flawed two-step load would be visible either as a time that changes on the low-word write alone or as a stale residue left after the load. The bench also lets the counter run between a capture and the word reads; a snapshot that followed the live count would return the advanced time. It also checks the wrap from 0xFF_FFFF_FFF8 to zero, high-word garbage above bit 7, and a load that lands on a tick cycle, which a design with the wrong priority would leave 8 ns ahead.

// File: rtl/ptp_clk_pkg.sv
package ptp_clk_pkg;

  localparam int WORD_W = 32;

  typedef enum logic [2:0] {
    REG_CTRL  = 3'd0,
    REG_INCR  = 3'd1,
    REG_RESID = 3'd2,
    REG_TLOW  = 3'd3,
    REG_THIGH = 3'd4
  } regSel_e;

  // Strobes from the register control to the time datapath
  typedef struct packed {
    logic              writeCtrl;
    logic              writeIncr;
    logic              loadTime;
    logic              captureSnap;
    logic [WORD_W-1:0] wrWord;
    logic [WORD_W-1:0] lowWord;
  } ctlStrobe_t;

endpackage

// File: rtl/ptp_reg_ctrl.sv
module ptp_reg_ctrl
  import ptp_clk_pkg::*;
#(
  parameter int NS_W   = 40,
  parameter int FRAC_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [2:0]        regAddr,
  input  logic [WORD_W-1:0] regWrData,
  input  logic              ctrlOff,
  input  logic [FRAC_W-1:0] incrReg,
  input  logic [FRAC_W-1:0] fracAcc,
  input  logic [NS_W-1:0]   snapNs,
  output ctlStrobe_t        str,
  output logic [WORD_W-1:0] regRdData
);

  localparam int HI_W = NS_W - WORD_W;

  logic [WORD_W-1:0] pendLow;
  logic [WORD_W-1:0] rdMux;

  // Low word is held until the high word completes the value
  always_ff @(posedge clk) begin
    if (rst) begin
      pendLow <= '0;
    end else if (regWrEn && regAddr == REG_TLOW) begin
      pendLow <= regWrData;
    end
  end

  always_comb begin
    str.writeCtrl   = regWrEn && (regAddr == REG_CTRL);
    str.writeIncr   = regWrEn && (regAddr == REG_INCR);
    str.loadTime    = regWrEn && (regAddr == REG_THIGH);
    str.captureSnap = regRdEn && (regAddr == REG_RESID);
    str.wrWord      = regWrData;
    str.lowWord     = pendLow;
  end

  always_comb begin
    case (regAddr)
      REG_CTRL:  rdMux = {ctrlOff, {(WORD_W-1){1'b0}}};
      REG_INCR:  rdMux = WORD_W'(incrReg);
      REG_RESID: rdMux = WORD_W'(fracAcc);
      REG_TLOW:  rdMux = snapNs[WORD_W-1:0];
      REG_THIGH: rdMux = WORD_W'(snapNs[NS_W-1:WORD_W]);
      default:   rdMux = '0;
    endcase
  end

  assign regRdData = regRdEn ? rdMux : '0;

  // R7: bits above the 40-bit count never show in the high word
  a_r7_high_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (regRdEn && regAddr == REG_THIGH) |-> (regRdData[WORD_W-1:HI_W] == '0));

  // R6: the held low word is what a high-word write loads
  a_r6_low_held: assert property (@(posedge clk) disable iff (rst)
    (regWrEn && regAddr == REG_TLOW) |=> (pendLow == $past(regWrData)));

endmodule

// File: rtl/ptp_time_core.sv
module ptp_time_core
  import ptp_clk_pkg::*;
#(
  parameter int NS_W    = 40,
  parameter int FRAC_W  = 32,
  parameter int STEP_NS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              baseTick,
  input  ctlStrobe_t        str,
  output logic [NS_W-1:0]   timeNs,
  output logic [FRAC_W-1:0] fracAcc,
  output logic [FRAC_W-1:0] incrReg,
  output logic              ctrlOff,
  output logic [NS_W-1:0]   snapNs
);

  localparam int HI_W = NS_W - WORD_W;

  logic              trimNeg;
  logic [FRAC_W-1:0] trimMag;
  logic [FRAC_W:0]   fracSum;
  logic [FRAC_W:0]   fracDiff;
  logic [FRAC_W-1:0] fracNext;
  logic [NS_W-1:0]   nsStep;
  logic              advance;

  always_comb begin
    trimNeg  = incrReg[FRAC_W-1];
    trimMag  = {1'b0, incrReg[FRAC_W-2:0]};
    fracSum  = {1'b0, fracAcc} + {1'b0, trimMag};
    fracDiff = {1'b0, fracAcc} - {1'b0, trimMag};
    if (trimNeg) begin
      fracNext = fracDiff[FRAC_W-1:0];
      nsStep   = NS_W'(STEP_NS) - NS_W'(fracDiff[FRAC_W]);
    end else begin
      fracNext = fracSum[FRAC_W-1:0];
      nsStep   = NS_W'(STEP_NS) + NS_W'(fracSum[FRAC_W]);
    end
    advance = baseTick && !ctrlOff;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      timeNs  <= '0;
      fracAcc <= '0;
      incrReg <= '0;
      ctrlOff <= 1'b1;
      snapNs  <= '0;
    end else begin
      if (str.writeCtrl) ctrlOff <= str.wrWord[WORD_W-1];
      if (str.writeIncr) incrReg <= FRAC_W'(str.wrWord);
      if (str.captureSnap) snapNs <= timeNs;
      if (str.loadTime) begin
        timeNs  <= {str.wrWord[HI_W-1:0], str.lowWord};
        fracAcc <= '0;
      end else if (advance) begin
        timeNs  <= timeNs + nsStep;
        fracAcc <= fracNext;
      end
    end
  end

  // R2, R3: time only moves on an enabled tick or a load
  a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    (!str.loadTime && !(baseTick && !ctrlOff)) |=> $stable(timeNs));

  // R3: a step is always 7, 8 or 9 ns
  a_r3_step_range: assert property (@(posedge clk) disable iff (rst)
    (advance && !str.loadTime) |=>
      (NS_W'(timeNs - $past(timeNs)) >= NS_W'(STEP_NS - 1) &&
       NS_W'(timeNs - $past(timeNs)) <= NS_W'(STEP_NS + 1)));

  // R4: a positive trim never shortens a step
  a_r4_pos_no_short: assert property (@(posedge clk) disable iff (rst)
    (advance && !str.loadTime && !incrReg[FRAC_W-1]) |=>
      (NS_W'(timeNs - $past(timeNs)) != NS_W'(STEP_NS - 1)));

  // R5: a negative trim never lengthens a step
  a_r5_neg_no_long: assert property (@(posedge clk) disable iff (rst)
    (advance && !str.loadTime && incrReg[FRAC_W-1]) |=>
      (NS_W'(timeNs - $past(timeNs)) != NS_W'(STEP_NS + 1)));

  // R6: a load leaves the accumulator empty
  a_r6_load_clears_frac: assert property (@(posedge clk) disable iff (rst)
    str.loadTime |=> (fracAcc == '0));

  // R8: the snapshot changes only on a residue read
  a_r8_snap_held: assert property (@(posedge clk) disable iff (rst)
    !str.captureSnap |=> $stable(snapNs));

endmodule

// File: rtl/ptp_rate_clock.sv
module ptp_rate_clock
  import ptp_clk_pkg::*;
#(
  parameter int NS_W    = 40,
  parameter int FRAC_W  = 32,
  parameter int STEP_NS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              baseTick,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [2:0]        regAddr,
  input  logic [WORD_W-1:0] regWrData,
  output logic [WORD_W-1:0] regRdData,
  output logic [NS_W-1:0]   timeNs
);

  ctlStrobe_t        str;
  logic [FRAC_W-1:0] fracAcc;
  logic [FRAC_W-1:0] incrReg;
  logic              ctrlOff;
  logic [NS_W-1:0]   snapNs;

  ptp_reg_ctrl #(.NS_W(NS_W), .FRAC_W(FRAC_W)) i_ctrl (
    .clk       (clk),
    .rst       (rst),
    .regWrEn   (regWrEn),
    .regRdEn   (regRdEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .ctrlOff   (ctrlOff),
    .incrReg   (incrReg),
    .fracAcc   (fracAcc),
    .snapNs    (snapNs),
    .str       (str),
    .regRdData (regRdData)
  );

  ptp_time_core #(.NS_W(NS_W), .FRAC_W(FRAC_W), .STEP_NS(STEP_NS)) i_core (
    .clk      (clk),
    .rst      (rst),
    .baseTick (baseTick),
    .str      (str),
    .timeNs   (timeNs),
    .fracAcc  (fracAcc),
    .incrReg  (incrReg),
    .ctrlOff  (ctrlOff),
    .snapNs   (snapNs)
  );

endmodule

// File: tb/test_ptp_rate_clock.sv
`timescale 1ns/1ps
module test_ptp_rate_clock;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        baseTick = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regRdEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [39:0] timeNs;

  int vectors = 0;
  int miscompares = 0;
  logic [31:0] rv;

  always #2.5 clk = ~clk;

  ptp_rate_clock i_ptp_rate_clock (
    .clk(clk), .rst(rst), .baseTick(baseTick), .regWrEn(regWrEn),
    .regRdEn(regRdEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .timeNs(timeNs)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(posedge clk); @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    regRdEn = 1'b1; regAddr = a;
    #1 d = regRdData;
    @(posedge clk); @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic ticks(input int n);
    baseTick = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
    end
    baseTick = 1'b0;
  endtask

  task automatic loadTime(input logic [31:0] lo, input logic [31:0] hi);
    wr(3'd3, lo);
    wr(3'd4, hi);
  endtask

  task automatic t_reset;
    rd(3'd0, rv); check("R1 ctrl", rv, 32'h8000_0000);
    rd(3'd1, rv); check("R1 incr", rv, 0);
    rd(3'd2, rv); check("R1 residue", rv, 0);
    check("R1 time", timeNs, 0);
  endtask

  task automatic t_disabled;
    ticks(10);
    check("R2 stopped", timeNs, 0);
  endtask

  task automatic t_nominal;
    wr(3'd0, 32'h0);
    ticks(5);
    check("R3 five ticks", timeNs, 40);
    repeat (3) @(negedge clk);
    check("R3 no tick", timeNs, 40);
  endtask

  task automatic t_time_write;
    wr(3'd1, 32'h4000_0000);
    ticks(1);
    check("R4 one tick", timeNs, 48);
    rd(3'd2, rv); check("R4 residue", rv, 32'h4000_0000);
    wr(3'd3, 32'h1234_5678);
    check("R6 low only", timeNs, 48);
    wr(3'd4, 32'hABCD_EF12);
    check("R6 loaded", timeNs, 40'h12_1234_5678);
    rd(3'd2, rv); check("R6 residue cleared", rv, 0);
    wr(3'd1, 32'h0);
  endtask

  task automatic t_pos_trim;
    wr(3'd1, 32'h4000_0000);
    loadTime(32'h0, 32'h0);
    ticks(3);
    check("R4 three ticks", timeNs, 24);
    rd(3'd2, rv); check("R4 residue", rv, 32'hC000_0000);
    ticks(1);
    check("R4 carry tick", timeNs, 33);
    rd(3'd1, rv); check("R9 incr pos", rv, 32'h4000_0000);
  endtask

  task automatic t_neg_trim;
    wr(3'd1, 32'hC000_0000);
    loadTime(32'h0, 32'h0);
    ticks(1);
    check("R5 borrow tick", timeNs, 7);
    rd(3'd2, rv); check("R5 residue", rv, 32'hC000_0000);
    ticks(3);
    check("R5 four ticks", timeNs, 31);
    rd(3'd1, rv); check("R9 incr neg", rv, 32'hC000_0000);
  endtask

  task automatic t_wrap;
    wr(3'd1, 32'h0);
    loadTime(32'hFFFF_FFF8, 32'hABCD_EFFF);
    rd(3'd2, rv);
    rd(3'd4, rv); check("R7 high word", rv, 32'h0000_00FF);
    rd(3'd3, rv); check("R7 low word", rv, 32'hFFFF_FFF8);
    ticks(1);
    check("R7 wrap", timeNs, 0);
  endtask

  task automatic t_snapshot;
    loadTime(32'h100, 32'h0);
    rd(3'd2, rv);
    ticks(5);
    check("R8 live moved", timeNs, 40'h128);
    rd(3'd3, rv); check("R8 snapshot held", rv, 32'h100);
    rd(3'd4, rv); check("R8 snapshot high", rv, 0);
    rd(3'd2, rv);
    rd(3'd3, rv); check("R8 recapture", rv, 32'h128);
  endtask

  task automatic t_load_vs_tick;
    wr(3'd3, 32'h500);
    regWrEn = 1'b1; regAddr = 3'd4; regWrData = 32'h0; baseTick = 1'b1;
    @(posedge clk); @(negedge clk);
    regWrEn = 1'b0; baseTick = 1'b0;
    check("R10 load wins", timeNs, 40'h500);
    ticks(1);
    check("R10 next tick", timeNs, 40'h508);
  endtask

  task automatic t_stop_again;
    wr(3'd0, 32'h8000_0000);
    ticks(4);
    check("R2 stopped again", timeNs, 40'h508);
    rd(3'd0, rv); check("R2 ctrl readback", rv, 32'h8000_0000);
  endtask

  initial begin
    #1000000;
    miscompares++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_disabled();
    t_nominal();
    t_time_write();
    t_pos_trim();
    t_neg_trim();
    t_wrap();
    t_snapshot();
    t_load_vs_tick();
    t_stop_again();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule